// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of device interrupt request lines and a processor. Each source has its own request input, its own enable bit, a programmable priority level and its own acknowledge output. Every cycle the block picks the highest-priority pending request among the enabled sources. It raises its interrupt output only when that request's level is strictly above the processor's running priority level.

When the processor answers with an acknowledge pulse, the block latches the winning source. It returns a short vector code for that source, made of a fixed base plus the source index. It also pulses the acknowledge line of that source for one cycle, so that the device can withdraw its request. Each line can be configured to capture leading edges or to follow the level of the line. On an edge-sensed line, a request held high produces exactly one interrupt.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, intOut, vecValid, vecOut and ackOut are all zero.
- R2: The winner is the pending, enabled source with the numerically largest level in srcLevel (source i occupies bits [i*PRIO_W +: PRIO_W]). When levels are equal, the lowest index wins.
- R3: intOut is a registered output. It is 1 exactly when a winner exists and its level is strictly greater than curLevel. A winner whose level equals curLevel gives 0.
- R4: A source whose maskEn bit is 0 never takes part in arbitration. A leading edge on an edge-sensed line is still captured while the line is masked, and it becomes eligible once the line is enabled.
- R5: An ackIn pulse while a request is accepted has two effects in the next cycle: vecValid=1 and vecOut=VEC_BASE+index of the winner. ackOut is one-hot on that source for one cycle only.
- R6: An ackIn pulse while no request is accepted gives vecValid=0 and leaves ackOut all zero.
- R7: When edgeSel bit i is 1, a 0-to-1 transition of reqIn[i] captures one event. A line kept high produces no further event.
- R8: A captured edge event is cleared when its source is acknowledged. The line then stays quiet until a new leading edge.
- R9: When edgeSel bit i is 0, the source is pending whenever reqIn[i] is 1, including directly after its acknowledge.
- R10: vecOut and vecValid change only on an ackIn pulse. Requests that change afterwards do not alter the returned vector.
- R11: intOut is 0 in the cycle following an ackIn pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Device request lines |
| edgeSel | input | NUM_SRC | 1 = leading-edge capture, 0 = level sensing, per line |
| maskEn | input | NUM_SRC | 1 = source enabled |
| srcLevel | input | NUM_SRC*PRIO_W | Packed priority level of each source |
| curLevel | input | PRIO_W | Processor's running priority level |
| ackIn | input | 1 | Processor acknowledge pulse |
| intOut | output | 1 | Interrupt to the processor |
| vecOut | output | VEC_W | Vector code of the acknowledged source |
| vecValid | output | 1 | vecOut holds a real source, not a spurious acknowledge |
| ackOut | output | NUM_SRC | One-cycle acknowledge back to the granted source |

## Verification
The bench sweeps all 256 request patterns of an eight-line configuration with rotating masks and running levels. For each pattern it compares the interrupt and vector against an arithmetic model.

Several corner cases get directed tests:
- Equal levels. A design that resolved ties toward the higher index would return the wrong vector.
- A winner equal to the running level. A comparison using "greater or equal" would interrupt here.
- A sustained edge-sensed line after acknowledge. A level-style capture would interrupt again.
- A pulse seen while masked. A design that gated capture with the mask would lose it.
- Requests that change after an acknowledge, and acknowledges with nothing accepted. A design that did not latch the vector would let it drift, or would report a valid vector it never had.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic grantLatch;  // capture winner, pulse its acknowledge
    logic ackMiss;     // acknowledge with nothing accepted
  } vicStrobe_t;
endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_SRC-1:0] edgeSel,
  input  logic [NUM_SRC-1:0] clrMask,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] edgeHit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic rising;
    assign rising = reqIn[g] && !reqPrev[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqPrev[g] <= 1'b0;
        edgeHit[g] <= 1'b0;
      end else begin
        reqPrev[g] <= reqIn[g];
        if (!edgeSel[g])      edgeHit[g] <= 1'b0;
        else if (rising)      edgeHit[g] <= 1'b1;
        else if (clrMask[g])  edgeHit[g] <= 1'b0;
      end
    end

    assign pending[g] = edgeSel[g] ? edgeHit[g] : reqIn[g];

    // R7
    edge_once_chk: assert property (@(posedge clk) disable iff (!rstN)
      (edgeSel[g] && reqPrev[g] && reqIn[g] && !edgeHit[g]) |=> !edgeHit[g]);
    // R8
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[g] && !rising) |=> !edgeHit[g]);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*PRIO_W-1:0] srcLevel,
  output logic                      winValid,
  output logic [IDX_W-1:0]          winIdx,
  output logic [PRIO_W-1:0]         winLevel
);
  logic [PRIO_W-1:0] lvlArr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : gLvl
    assign lvlArr[g] = srcLevel[g*PRIO_W +: PRIO_W];
  end

  // ascending scan with strict compare: ties keep the lower index
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLevel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!winValid || lvlArr[i] > winLevel)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winLevel = lvlArr[i];
      end
    end
  end

  // R2
  win_is_cand_chk: assert final (!winValid || cand[winIdx]);
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int PRIO_W   = 3,
  parameter int VEC_W    = 5,
  parameter int VEC_BASE = 16,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        reqIn,
  input  logic [NUM_SRC-1:0]        edgeSel,
  input  logic [NUM_SRC-1:0]        maskEn,
  input  logic [NUM_SRC*PRIO_W-1:0] srcLevel,
  input  logic [PRIO_W-1:0]         curLevel,
  input  vicStrobe_t                strobe,
  output logic                      accept,
  output logic [VEC_W-1:0]          vecOut,
  output logic                      vecValid,
  output logic [NUM_SRC-1:0]        ackOut
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] clrMask;
  logic               winValid;
  logic [IDX_W-1:0]   winIdx;
  logic [PRIO_W-1:0]  winLevel;
  logic [NUM_SRC-1:0] winOneHot;

  assign winOneHot = NUM_SRC'(1) << winIdx;
  assign clrMask   = strobe.grantLatch ? winOneHot : '0;

  vic_sense #(.NUM_SRC(NUM_SRC)) uSense (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .edgeSel(edgeSel),
    .clrMask(clrMask), .pending(pending)
  );

  vic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uArb (
    .cand(pending & maskEn), .srcLevel(srcLevel),
    .winValid(winValid), .winIdx(winIdx), .winLevel(winLevel)
  );

  assign accept = winValid && (winLevel > curLevel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
      ackOut   <= '0;
    end else begin
      ackOut <= '0;
      if (strobe.grantLatch) begin
        vecOut   <= VEC_W'(VEC_BASE) + VEC_W'(winIdx);
        vecValid <= 1'b1;
        ackOut   <= winOneHot;
      end else if (strobe.ackMiss) begin
        vecValid <= 1'b0;
      end
    end
  end

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut));
  // R5
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |-> vecValid);
  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.grantLatch || strobe.ackMiss) |=> ($stable(vecOut) && $stable(vecValid)));
  // R3
  accept_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (winLevel > curLevel));
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       ackIn,
  output vicStrobe_t strobe,
  output logic       intOut
);
  always_comb begin
    strobe.grantLatch = ackIn && accept;
    strobe.ackMiss    = ackIn && !accept;
  end

  // acknowledged request is being retired: hold the line low for a cycle
  always_ff @(posedge clk) begin
    if (!rstN) intOut <= 1'b0;
    else       intOut <= accept && !ackIn;
  end

  // R11
  quiet_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIn |=> !intOut);
  // R3
  int_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accept) |=> !intOut);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int PRIO_W   = 3,
  parameter int VEC_W    = 5,
  parameter int VEC_BASE = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        reqIn,
  input  logic [NUM_SRC-1:0]        edgeSel,
  input  logic [NUM_SRC-1:0]        maskEn,
  input  logic [NUM_SRC*PRIO_W-1:0] srcLevel,
  input  logic [PRIO_W-1:0]         curLevel,
  input  logic                      ackIn,
  output logic                      intOut,
  output logic [VEC_W-1:0]          vecOut,
  output logic                      vecValid,
  output logic [NUM_SRC-1:0]        ackOut
);
  vicStrobe_t strobe;
  logic       accept;

  vic_control uCtl (
    .clk(clk), .rstN(rstN), .accept(accept), .ackIn(ackIn),
    .strobe(strobe), .intOut(intOut)
  );

  vic_datapath #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .edgeSel(edgeSel),
    .maskEn(maskEn), .srcLevel(srcLevel), .curLevel(curLevel),
    .strobe(strobe), .accept(accept), .vecOut(vecOut),
    .vecValid(vecValid), .ackOut(ackOut)
  );

  // R5
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|ackOut) |-> $past(ackIn));
  // R6
  miss_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !accept) |=> (ackOut == '0 && !vecValid));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int VW = 5;
  localparam int VB = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqIn, edgeSel, maskEn;
  logic [N*PW-1:0] srcLevel;
  logic [PW-1:0] curLevel;
  logic          ackIn;
  logic          intOut, vecValid;
  logic [VW-1:0] vecOut;
  logic [N-1:0]  ackOut;

  int nRun = 0;
  int nFail = 0;
  int lvl [N];

  always #5 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .PRIO_W(PW), .VEC_W(VW), .VEC_BASE(VB)) u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .edgeSel(edgeSel), .maskEn(maskEn),
    .srcLevel(srcLevel), .curLevel(curLevel), .ackIn(ackIn), .intOut(intOut),
    .vecOut(vecOut), .vecValid(vecValid), .ackOut(ackOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic setLevels();
    for (int i = 0; i < N; i++) srcLevel[i*PW +: PW] = PW'(lvl[i]);
  endtask

  // bench model of arbitration
  task automatic refWin(input logic [N-1:0] cand, output bit v, output int idx, output int lv);
    v = 0; idx = 0; lv = 0;
    for (int i = 0; i < N; i++)
      if (cand[i] && (!v || lvl[i] > lv)) begin v = 1; idx = i; lv = lvl[i]; end
  endtask

  task automatic doAck();
    ackIn = 1'b1;
    tick(1);
    ackIn = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit v; int idx; int lv; bit expInt;
    rstN = 0; reqIn = '0; edgeSel = '0; maskEn = '1; curLevel = '0; ackIn = 0;
    for (int i = 0; i < N; i++) lvl[i] = (i * 3 + 1) % 8;
    setLevels();
    tick(3);
    // R1 reset state
    check(intOut == 0 && vecValid == 0 && ackOut == 0 && vecOut == 0, "R1", int'(intOut), 0);
    rstN = 1;
    tick(2);

    // R2 R3 R5 R6 sweep over all level-sensed request patterns
    for (int p = 0; p < 256; p++) begin
      reqIn    = N'(p);
      maskEn   = (p % 4 == 3) ? 8'h5A : 8'hFF;
      curLevel = PW'(p % 8);
      refWin(reqIn & maskEn, v, idx, lv);
      expInt = v && (lv > (p % 8));
      tick(2);
      check(intOut == expInt, "R3", int'(intOut), int'(expInt));
      doAck();
      if (expInt) begin
        check(vecValid && vecOut == VW'(VB + idx), "R2", int'(vecOut), VB + idx);
        check(ackOut == (N'(1) << idx), "R5", int'(ackOut), 1 << idx);
        check(intOut == 0, "R11", int'(intOut), 0);
      end else begin
        check(vecValid == 0 && ackOut == 0, "R6", int'(ackOut), 0);
      end
      tick(1);
      check(ackOut == 0, "R5 pulse width", int'(ackOut), 0);
      reqIn = '0;
      tick(1);
    end

    // R2 ties resolve to lower index
    for (int i = 0; i < N; i++) lvl[i] = 4;
    setLevels();
    maskEn = '1; curLevel = 0; reqIn = 8'b0110_1000;
    tick(2);
    doAck();
    check(vecOut == VW'(VB + 3), "R2 tie", int'(vecOut), VB + 3);
    reqIn = '0;
    // R3 equal level does not interrupt
    curLevel = 4; reqIn = 8'b0000_0100;
    tick(3);
    check(intOut == 0, "R3 equal", int'(intOut), 0);
    curLevel = 3;
    tick(2);
    check(intOut == 1, "R3 above", int'(intOut), 1);
    reqIn = '0; curLevel = 0;
    for (int i = 0; i < N; i++) lvl[i] = (i * 3 + 1) % 8;
    setLevels();
    tick(2);

    // R7 R8 edge sensing with sustained line
    edgeSel = '1;
    tick(2);
    reqIn[4] = 1'b1;
    tick(3);
    check(intOut == 1, "R7 capture", int'(intOut), 1);
    doAck();
    check(vecOut == VW'(VB + 4) && ackOut == 8'h10, "R5 edge vec", int'(vecOut), VB + 4);
    tick(4);
    check(intOut == 0, "R8 sustained line", int'(intOut), 0);
    check(vecOut == VW'(VB + 4) && vecValid, "R10 hold", int'(vecOut), VB + 4);
    reqIn[4] = 1'b0;
    tick(1);
    reqIn[4] = 1'b1;
    tick(3);
    check(intOut == 1, "R7 new edge", int'(intOut), 1);
    doAck();
    reqIn = '0;
    tick(2);

    // R4 edge pulse captured while masked
    maskEn = 8'hFD;
    reqIn[1] = 1'b1;
    tick(1);
    reqIn[1] = 1'b0;
    tick(3);
    check(intOut == 0, "R4 masked", int'(intOut), 0);
    maskEn = '1;
    tick(2);
    check(intOut == 1, "R4 unmasked", int'(intOut), 1);
    doAck();
    check(vecOut == VW'(VB + 1), "R4 vec", int'(vecOut), VB + 1);
    tick(2);

    // R9 level source remains pending after acknowledge
    edgeSel = '0;
    reqIn[6] = 1'b1;
    tick(2);
    doAck();
    check(vecOut == VW'(VB + 6), "R9 vec", int'(vecOut), VB + 6);
    check(intOut == 0, "R11 level", int'(intOut), 0);
    tick(1);
    check(intOut == 1, "R9 still pending", int'(intOut), 1);

    // R10 vector latched despite later request changes
    reqIn[2] = 1'b1;
    tick(2);
    doAck();
    reqIn = '0;
    check(vecOut == VW'(VB + 2), "R10 latch", int'(vecOut), VB + 2);
    tick(3);
    check(vecOut == VW'(VB + 2) && vecValid, "R10 stable", int'(vecOut), VB + 2);
    check(intOut == 0, "R3 idle", int'(intOut), 0);

    // R6 spurious acknowledge clears valid
    doAck();
    check(vecValid == 0 && ackOut == 0, "R6 idle ack", int'(vecValid), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule